// File: doc/BRIEF.md
# Capture/Compare Timer with Clear-After-Read Status Flags

The block is a free-running up-counter shared by four channels. Each channel owns a general register that acts either as a capture register or as a compare register. In capture mode a chosen edge on the channel's input pin is synchronised and detected. The counter value is then copied into the general register. In compare mode the channel fires when the running counter equals its general register. Every channel event, and every wrap of the counter, raises a sticky flag in an 8-bit status word.

Software reaches all state through a simple register bus: address, write strobe, read strobe, write data and combinational read data. A flag can be cleared by writing 0 to it, but only after software has read that same flag as 1. This protects against losing an event that arrives between the read and the write. A per-channel acknowledge from a transfer engine also clears a channel's flag, if that channel's interrupt is enabled. Each channel drives its own interrupt request.

Register map (address: content):
- 0, control: bit 0 run; bit 1+i selects capture mode for channel i (1 = capture, 0 = compare); bits 9+2i:8+2i hold the edge select for channel i.
- 1, interrupt enable: bit i enables channel i.
- 2, counter.
- 3, status.
- 4+i, general register of channel i.

All registers are 16 bits. Control and enable read back every written bit.

Top module: `ccf_timer`

## Requirements
- R1: After reset, the status register reads 0x0070, the counter and all general registers read 0, and irq_o is 0.
- R2: In the status word, bit i (i = 0..3) is the flag of channel i and bit 7 is the overflow flag. Bits 4..6 always read 1, and writes to them have no effect.
- R3: While control bit 0 is 1, the counter increases by 1 on every clock. While it is 0, the counter holds. A bus write to address 2 loads the counter.
- R4: In capture mode the input passes through a two-flop synchroniser. The edge select works as follows: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the counter into the channel's general register and sets the channel flag. Other edges change neither.
- R5: In compare mode, with the counter running, a counter value equal to the general register sets the channel flag on the following clock.
- R6: The overflow flag (status bit 7) is set on the clock where the running counter goes from 0xFFFF to 0x0000.
- R7: Writing 0 to a status flag clears it only if a bus read of the status word returned that flag as 1 since the flag's last clear. Writing 1 never changes a flag. A clearing write also consumes the read, so a later 0 write needs a new read.
- R8: A pulse on xfer_ack_i[i] clears channel i's flag when interrupt enable bit i is 1. When that enable bit is 0, the pulse is ignored.
- R9: When a set event and a clear for the same flag fall in the same clock, the flag ends up 1.
- R10: irq_o[i] is 1 exactly when channel i's flag and its enable bit are both 1.
- R11: General registers can be written and read back over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| rd_en_i | input | 1 | Read strobe, marks a software read for the arm logic |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| cap_i | input | 4 | Channel capture inputs, asynchronous |
| xfer_ack_i | input | 4 | Per-channel acknowledge from the transfer engine |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
On every cycle the checker confirms several properties:
- the counter steps or holds as the run bit dictates;
- a wrap of the running counter raises the overflow flag;
- any set event leaves its flag at 1 on the next cycle;
- a flag with no armed read and no acknowledge cannot drop;
- an acknowledge with no competing event clears its flag;
- the unused status bits read as 1.

Other behaviours can only be shown by the bench's scenarios. These are the edge-select decoding through the synchroniser delay, the value latched on capture, the exact cycle of a compare match, and the read-then-write clearing order. Also scenario-only are the same-cycle race between a capture and a clearing write, and the interrupt gating.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_IEN  = 1;
  localparam int unsigned ADR_CNT  = 2;
  localparam int unsigned ADR_STAT = 3;
  localparam int unsigned ADR_GR0  = 4;

  localparam int unsigned STAT_W        = 8;
  localparam int unsigned OVF_POS       = 7;
  localparam int unsigned CTRL_MODE_LSB = 1;
  localparam int unsigned CTRL_EDGE_LSB = 8;
endpackage

// File: rtl/ccf_counter.sv
module ccf_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  // a bus load overrides the wrap
  always_comb wrap_o = run_i && !load_i && (cnt_q == {CNT_W{1'b1}});
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ccf_edge_sync.sv
module ccf_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               din_i,
  input  ccf_pkg::edge_sel_e sel_i,
  output logic               hit_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  // sh_q[SYNC_STAGES-1] is the synchronised level, sh_q[SYNC_STAGES] its previous value
  logic [SH_W-1:0] sh_q;
  logic            cur, prev, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], din_i};
  end

  always_comb begin
    cur  = sh_q[SYNC_STAGES-1];
    prev = sh_q[SYNC_STAGES];
    rise = cur && !prev;
    fall = !cur && prev;
    unique case (sel_i)
      ccf_pkg::EDGE_RISE: hit_o = rise;
      ccf_pkg::EDGE_FALL: hit_o = fall;
      ccf_pkg::EDGE_BOTH: hit_o = rise || fall;
      default:            hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccf_channel.sv
module ccf_channel #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_in_i,
  input  logic               capture_i,
  input  ccf_pkg::edge_sel_e edge_sel_i,
  input  logic               run_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               gr_wr_i,
  input  logic [CNT_W-1:0]   gr_wdata_i,
  output logic [CNT_W-1:0]   gr_o,
  output logic               evt_o
);
  logic [CNT_W-1:0] gr_q;
  logic             edge_hit, cap_evt, cmp_evt;

  ccf_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (cap_in_i),
    .sel_i  (edge_sel_i),
    .hit_o  (edge_hit)
  );

  always_comb begin
    cap_evt = capture_i && edge_hit;
    cmp_evt = !capture_i && run_i && (cnt_i == gr_q);
    evt_o   = cap_evt || cmp_evt;
  end

  // a capture beats a bus write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gr_q <= '0;
    else if (cap_evt) gr_q <= cnt_i;
    else if (gr_wr_i) gr_q <= gr_wdata_i;
  end

  assign gr_o = gr_q;
endmodule

// File: rtl/ccf_status.sv
module ccf_status #(
  parameter int unsigned NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [NF-1:0] wbits_i,
  input  logic [NF-1:0] ack_clr_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] arm_o
);
  logic [NF-1:0] flag_q, arm_q;

  for (genvar b = 0; b < NF; b++) begin : g_bit
    logic wr_clr, clr, flag_d, arm_d;

    always_comb begin
      wr_clr = wr_i && !wbits_i[b] && arm_q[b];
      clr    = wr_clr || ack_clr_i[b];
      flag_d = set_i[b] ? 1'b1 : (clr ? 1'b0 : flag_q[b]);
      arm_d  = clr ? 1'b0 : (arm_q[b] || (rd_i && flag_q[b]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[b] <= 1'b0;
        arm_q[b]  <= 1'b0;
      end else begin
        flag_q[b] <= flag_d;
        arm_q[b]  <= arm_d;
      end
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/ccf_timer.sv
module ccf_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned N_CH        = 4,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   cap_i,
  input  logic [N_CH-1:0]   xfer_ack_i,
  output logic [N_CH-1:0]   irq_o
);
  import ccf_pkg::*;

  localparam int unsigned NF     = N_CH + 1;
  localparam int unsigned OVF_IX = N_CH;

  logic [CNT_W-1:0] ctrl_q, ien_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gr [N_CH];
  logic [N_CH-1:0]  ch_evt;
  logic             run, cnt_load, wrap;
  logic             stat_rd, stat_wr;
  logic [NF-1:0]    set_vec, flag, arm, ack_clr, stat_wbits;
  logic [STAT_W-1:0] stat_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(ADR_CTRL)) ctrl_q <= wdata_i;
      if (addr_i == ADDR_W'(ADR_IEN))  ien_q  <= wdata_i;
    end
  end

  always_comb begin
    run      = ctrl_q[0];
    cnt_load = wr_en_i && (addr_i == ADDR_W'(ADR_CNT));
    stat_rd  = rd_en_i && (addr_i == ADDR_W'(ADR_STAT));
    stat_wr  = wr_en_i && (addr_i == ADDR_W'(ADR_STAT));
  end

  ccf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic gr_wr;
    assign gr_wr = wr_en_i && (addr_i == ADDR_W'(ADR_GR0 + i));

    ccf_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_in_i   (cap_i[i]),
      .capture_i  (ctrl_q[CTRL_MODE_LSB + i]),
      .edge_sel_i (edge_sel_e'(ctrl_q[CTRL_EDGE_LSB + 2*i +: 2])),
      .run_i      (run),
      .cnt_i      (cnt),
      .gr_wr_i    (gr_wr),
      .gr_wdata_i (wdata_i),
      .gr_o       (gr[i]),
      .evt_o      (ch_evt[i])
    );
  end

  always_comb begin
    set_vec    = {wrap, ch_evt};
    ack_clr    = {1'b0, xfer_ack_i & ien_q[N_CH-1:0]};
    stat_wbits = {wdata_i[OVF_POS], wdata_i[N_CH-1:0]};
  end

  ccf_status #(.NF(NF)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .rd_i      (stat_rd),
    .wr_i      (stat_wr),
    .wbits_i   (stat_wbits),
    .ack_clr_i (ack_clr),
    .flag_o    (flag),
    .arm_o     (arm)
  );

  // unassigned status bits read as 1
  always_comb begin
    stat_v            = {1'b0, {(STAT_W-1){1'b1}}};
    stat_v[N_CH-1:0]  = flag[N_CH-1:0];
    stat_v[OVF_POS]   = flag[OVF_IX];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(ADR_IEN))  rdata_o = ien_q;
    if (addr_i == ADDR_W'(ADR_CNT))  rdata_o = cnt;
    if (addr_i == ADDR_W'(ADR_STAT)) rdata_o = {{(CNT_W-STAT_W){1'b0}}, stat_v};
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(ADR_GR0 + i)) rdata_o = gr[i];
    end
  end

  assign irq_o = flag[N_CH-1:0] & ien_q[N_CH-1:0];
endmodule

// File: rtl/ccf_timer_chk.sv
module ccf_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  rdata_o,
  input logic              run,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  cnt,
  input logic [N_CH:0]     set_vec,
  input logic [N_CH:0]     flag,
  input logic [N_CH:0]     arm,
  input logic [N_CH:0]     ack_clr
);
  a_r2_unused_read_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ccf_pkg::ADR_STAT)) |-> (rdata_o[6:4] == 3'b111))
    else $error("R2 unused status bits not 1");

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cnt_load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)))
    else $error("R3 counter did not step");

  a_r3_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_load) |=> $stable(cnt))
    else $error("R3 stopped counter moved");

  a_r6_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cnt_load && (cnt == {CNT_W{1'b1}})) |=> flag[N_CH])
    else $error("R6 wrap did not set overflow flag");

  for (genvar b = 0; b <= N_CH; b++) begin : g_bit
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[b] |=> flag[b])
      else $error("R9 set event lost on bit %0d", b);

    a_r7_unarmed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag[b] && !arm[b] && !ack_clr[b]) |=> flag[b])
      else $error("R7 unarmed flag %0d dropped", b);

    a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_clr[b] && !set_vec[b]) |=> !flag[b])
      else $error("R8 acknowledge did not clear bit %0d", b);
  end
endmodule

bind ccf_timer ccf_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .run      (run),
  .cnt_load (cnt_load),
  .cnt      (cnt),
  .set_vec  (set_vec),
  .flag     (flag),
  .arm      (arm),
  .ack_clr  (ack_clr)
);

// File: tb/ccf_timer_tb.sv
module ccf_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0, A_IEN = 1, A_CNT = 2, A_STAT = 3, A_GR0 = 4;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  cap = '0, ack = '0, irq;

  int n_chk = 0, n_err = 0;
  logic [15:0] exp_gr [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccf_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .xfer_ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [15:0] v);
    @(negedge clk); addr = 3'(a); wdata = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 3'(a); rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input int a, output logic [15:0] d);
    addr = 3'(a); #1 d = rdata;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_rd(A_STAT, d);
    bus_wr(A_STAT, 16'h0000);
  endtask

  function automatic logic edge_hit(input logic [1:0] sel, input logic from, input logic to);
    return (sel[0] && !from && to) || (sel[1] && from && !to);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d, v1, c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(A_STAT, d); chk("R1 status", d, 16'h0070);
    peek(A_CNT, d);  chk("R1 counter", d, 16'h0000);
    for (int i = 0; i < 4; i++) begin peek(A_GR0 + i, d); chk("R1 gr", d, 16'h0000); end
    chk("R1 irq", {12'h0, irq}, 16'h0000);

    // R2 unused bits ignore writes, writing 1 sets nothing
    bus_wr(A_STAT, 16'h0000); peek(A_STAT, d); chk("R2 write zeros", d, 16'h0070);
    bus_wr(A_STAT, 16'h00FF); peek(A_STAT, d); chk("R2 write ones", d, 16'h0070);

    // R11 general register access
    for (int i = 0; i < 4; i++) begin
      exp_gr[i] = 16'($urandom);
      bus_wr(A_GR0 + i, exp_gr[i]);
    end
    for (int i = 0; i < 4; i++) begin peek(A_GR0 + i, d); chk("R11 gr readback", d, exp_gr[i]); end

    // R3 counting, load and hold
    bus_wr(A_CTRL, 16'h001E);
    bus_wr(A_CNT, 16'h1234); peek(A_CNT, d); chk("R3 load", d, 16'h1234);
    bus_wr(A_CTRL, 16'h001F);
    peek(A_CNT, v1); @(negedge clk); peek(A_CNT, d); chk("R3 step", d, v1 + 16'd1);
    repeat (4) @(negedge clk); peek(A_CNT, d); chk("R3 run", d, v1 + 16'd5);
    bus_wr(A_CTRL, 16'h001E);
    peek(A_CNT, v1); repeat (3) @(negedge clk); peek(A_CNT, d); chk("R3 hold", d, v1);
    clear_all();

    // R5 compare match timing, random channel, start and distance
    for (int it = 0; it < 10; it++) begin
      int ch, k;
      logic [15:0] modes;
      ch = int'($urandom_range(0, 3));
      k = int'($urandom_range(2, 20));
      c = 16'($urandom_range(0, 16'hEFFF));
      modes = 16'((~(4'b1 << ch) & 4'hF) << 1);
      bus_wr(A_CTRL, modes);
      bus_wr(A_CNT, c);
      exp_gr[ch] = c + 16'(k);
      bus_wr(A_GR0 + ch, exp_gr[ch]);
      bus_wr(A_CTRL, modes | 16'h1);
      repeat (k) @(negedge clk);
      peek(A_STAT, d); chk("R5 before match", {15'h0, d[ch]}, 16'h0);
      @(negedge clk);
      peek(A_STAT, d); chk("R5 after match", {15'h0, d[ch]}, 16'h1);
      bus_wr(A_CTRL, modes);
      clear_all();
      peek(A_STAT, d); chk("R7 cleared after read", d, 16'h0070);
    end

    // R6 overflow
    bus_wr(A_CTRL, 16'h001E);
    bus_wr(A_CNT, 16'hFFFE);
    bus_wr(A_CTRL, 16'h001F);
    @(negedge clk); peek(A_STAT, d); chk("R6 no flag at FFFF", {15'h0, d[7]}, 16'h0);
    @(negedge clk); peek(A_STAT, d); chk("R6 flag after wrap", {15'h0, d[7]}, 16'h1);
    peek(A_CNT, d); chk("R6 counter wrapped", d, 16'h0000);
    bus_wr(A_CTRL, 16'h001E);
    clear_all();

    // R4 directed: ch0 rise, ch1 fall, ch2 both, ch3 none
    bus_wr(A_CTRL, 16'h391E);
    bus_wr(A_CNT, 16'h0ABC);
    @(negedge clk); cap = 4'hF;
    repeat (4) @(negedge clk);
    peek(A_STAT, d); chk("R4 rising edges", d, 16'h0075);
    exp_gr[0] = 16'h0ABC; exp_gr[2] = 16'h0ABC;
    for (int i = 0; i < 4; i++) begin peek(A_GR0 + i, d); chk("R4 gr after rise", d, exp_gr[i]); end
    bus_wr(A_CNT, 16'h0DEF);
    @(negedge clk); cap = 4'h0;
    repeat (4) @(negedge clk);
    peek(A_STAT, d); chk("R4 falling edges", d, 16'h0077);
    exp_gr[1] = 16'h0DEF; exp_gr[2] = 16'h0DEF;
    for (int i = 0; i < 4; i++) begin peek(A_GR0 + i, d); chk("R4 gr after fall", d, exp_gr[i]); end
    clear_all();

    // R4 random capture
    for (int it = 0; it < 16; it++) begin
      int ch;
      logic [1:0] sel;
      logic from, to, hit;
      ch = int'($urandom_range(0, 3));
      sel = 2'($urandom);
      c = 16'($urandom);
      bus_wr(A_CTRL, 16'h001E | (16'(sel) << (8 + 2*ch)));
      bus_wr(A_CNT, c);
      from = cap[ch]; to = ~from;
      hit = edge_hit(sel, from, to);
      @(negedge clk); cap[ch] = to;
      repeat (4) @(negedge clk);
      if (hit) exp_gr[ch] = c;
      peek(A_STAT, d); chk("R4 random flag", {15'h0, d[ch]}, {15'h0, hit});
      peek(A_GR0 + ch, d); chk("R4 random gr", d, exp_gr[ch]);
      clear_all();
    end

    // R7 clear only after read; write 1 keeps flag
    bus_wr(A_CTRL, 16'h031E);
    @(negedge clk); cap[0] = ~cap[0]; repeat (4) @(negedge clk);
    bus_wr(A_STAT, 16'h0000); peek(A_STAT, d); chk("R7 write0 without read", {15'h0, d[0]}, 16'h1);
    bus_rd(A_STAT, d); chk("R7 read shows flag", {15'h0, d[0]}, 16'h1);
    bus_wr(A_STAT, 16'h0001); peek(A_STAT, d); chk("R7 write1 keeps", {15'h0, d[0]}, 16'h1);
    bus_wr(A_STAT, 16'h0000); peek(A_STAT, d); chk("R7 write0 after read", {15'h0, d[0]}, 16'h0);
    @(negedge clk); cap[0] = ~cap[0]; repeat (4) @(negedge clk);
    bus_wr(A_STAT, 16'h0000); peek(A_STAT, d); chk("R7 read consumed", {15'h0, d[0]}, 16'h1);

    // R9 capture coincides with a clearing write
    bus_rd(A_STAT, d);
    @(negedge clk); cap[0] = ~cap[0];
    @(negedge clk);
    @(negedge clk); addr = 3'(A_STAT); wdata = 16'h0000; wr_en = 1;
    @(negedge clk); wr_en = 0;
    peek(A_STAT, d); chk("R9 set wins", {15'h0, d[0]}, 16'h1);
    clear_all();
    peek(A_STAT, d); chk("R9 later clear", {15'h0, d[0]}, 16'h0);

    // R8 and R10 acknowledge and interrupt gating
    @(negedge clk); cap[0] = ~cap[0]; repeat (4) @(negedge clk);
    chk("R10 irq disabled", {12'h0, irq}, 16'h0);
    @(negedge clk); ack = 4'h1; @(negedge clk); ack = 4'h0;
    peek(A_STAT, d); chk("R8 ack ignored when disabled", {15'h0, d[0]}, 16'h1);
    bus_wr(A_IEN, 16'h0001);
    chk("R10 irq enabled", {12'h0, irq}, 16'h1);
    @(negedge clk); ack = 4'h2; @(negedge clk); ack = 4'h0;
    peek(A_STAT, d); chk("R8 other channel ack", {15'h0, d[0]}, 16'h1);
    @(negedge clk); ack = 4'h1; @(negedge clk); ack = 4'h0;
    peek(A_STAT, d); chk("R8 ack clears", {15'h0, d[0]}, 16'h0);
    chk("R10 irq after clear", {12'h0, irq}, 16'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule